// File: doc/BRIEF.md
# Padded Row Loader

This block moves one row at a time from a byte-addressed global memory into a local buffer built from 32-byte words. A row descriptor gives the source byte address, the 32-byte-aligned destination byte address, the number of bytes to copy and the destination stride. A one-bit pad select chooses whether the rest of the destination row, from the copied bytes up to the stride, is filled with a pad byte held in a small configuration register.

The loader sends one read request per row. The request carries the source address and the length, and the memory returns the row as a stream of single-byte beats. Each beat is steered into the byte lane that matches its row offset. Full words, and the final partial word, are written to the buffer with per-byte enables. When padding is on, pad bytes are merged into the final data word in the same write, and any further words up to the stride are written as pad-only words. A stream identifier and a cache hint travel with each descriptor but have no effect.

Top module: `row_mover`

## Requirements
- R1: After reset, `desc_ready` is 1, `rd_req_valid` is 0 and `wr_en` is 0.
- R2: A row with a nonzero length issues exactly one read request with `rd_req_addr` equal to the descriptor source and `rd_req_len` equal to the length. The request holds steady until `rd_req_ready` is seen. A zero-length row issues no request.
- R3: Source byte k of a row (k < length) is written to buffer word `dst/32 + k/32`, lane `k%32`, where lane i is `wr_data[8i+7:8i]` enabled by `wr_be[i]`. This placement does not depend on the source alignment.
- R4: With the pad select set, every byte at row offset from the length up to stride-1 is written with the pad value. Bytes at or past the stride are not written. Pad bytes that share a word with data go out in the same write as that data.
- R5: With the pad select clear, no byte at a row offset at or above the length is written.
- R6: A write strobe `pad_we` loads `pad_wdata` into the pad register. Every row accepted after that uses the new value.
- R7: A zero-length row with the pad select set writes only pad bytes, covering offsets 0 to stride-1. A zero-length row without padding writes nothing.
- R8: `desc_ready` drops in the cycle after a row that has work is accepted. It returns only once the final buffer write of that row has been issued, and no read request is pending while it is high.
- R9: `desc_sid` and `desc_hint` have no effect on any output.
- R10: A row issues exactly ceil(L/32) writes, where L is the stride with padding and the length without. The word addresses strictly increase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_we | input | 1 | Load pad register |
| pad_wdata | input | 8 | New pad byte |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Loader idle, descriptor taken when valid |
| desc_src | input | SRC_AW | Source byte address |
| desc_dst | input | BUF_AW+5 | Destination byte address, 32-byte aligned |
| desc_len | input | LEN_W | Bytes to copy |
| desc_stride | input | LEN_W | Destination row stride in bytes (>= length) |
| desc_pad_en | input | 1 | Pad select |
| desc_sid | input | SID_W | Stream identifier, ignored |
| desc_hint | input | HINT_W | Cache hint, ignored |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | SRC_AW | Read start byte address |
| rd_req_len | output | LEN_W | Read byte count |
| rd_beat_valid | input | 1 | Returned byte valid |
| rd_beat_data | input | 8 | Returned byte |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | BUF_AW | Buffer word address |
| wr_data | output | 256 | Buffer write word |
| wr_be | output | 32 | Per-byte write enables |

## Verification
The assertions take three things for granted about the inputs. The stride is at least the length. The destination is 32-byte aligned. The memory returns exactly the requested number of beats, in order, only after the request is accepted, and never overlaps two rows. The bench memory model starts a beat stream only on an accepted request and stops after the requested count. It inserts idle gaps and stalls the request handshake on a fixed pattern. Every descriptor it sends has a stride no smaller than its length and an aligned destination, in a region of the buffer that is not shared with any other row.

// File: rtl/row_mover_pkg.sv
package row_mover_pkg;
  localparam int WORD_BYTES = 32;
  localparam int LANE_W     = 5;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_DATA, ST_PAD} rm_state_e;
endpackage

// File: rtl/rm_pad_reg.sv
module rm_pad_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)     value <= '0;
    else if (we) value <= wdata;
  end
endmodule

// File: rtl/rm_lane_mask.sv
// Lane l is selected when l >= lo and base + l < limit.
module rm_lane_mask #(
  parameter int LANES = 32,
  parameter int PW    = 17,
  parameter int LO_W  = 6
) (
  input  logic [PW-1:0]    base,
  input  logic [PW-1:0]    limit,
  input  logic [LO_W-1:0]  lo,
  output logic [LANES-1:0] mask
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mask[l] = (lo <= LO_W'(l)) && ((base + PW'(l)) < limit);
  end
endmodule

// File: rtl/row_mover.sv
module row_mover
  import row_mover_pkg::*;
#(
  parameter int SRC_AW = 40,
  parameter int BUF_AW = 10,
  parameter int LEN_W  = 16,
  parameter int SID_W  = 4,
  parameter int HINT_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pad_we,
  input  logic [7:0]              pad_wdata,
  input  logic                    desc_valid,
  output logic                    desc_ready,
  input  logic [SRC_AW-1:0]       desc_src,
  input  logic [BUF_AW+4:0]       desc_dst,
  input  logic [LEN_W-1:0]        desc_len,
  input  logic [LEN_W-1:0]        desc_stride,
  input  logic                    desc_pad_en,
  input  logic [SID_W-1:0]        desc_sid,
  input  logic [HINT_W-1:0]       desc_hint,
  output logic                    rd_req_valid,
  input  logic                    rd_req_ready,
  output logic [SRC_AW-1:0]       rd_req_addr,
  output logic [LEN_W-1:0]        rd_req_len,
  input  logic                    rd_beat_valid,
  input  logic [7:0]              rd_beat_data,
  output logic                    wr_en,
  output logic [BUF_AW-1:0]       wr_addr,
  output logic [WORD_BYTES*8-1:0] wr_data,
  output logic [WORD_BYTES-1:0]   wr_be
);
  localparam int PW   = LEN_W + 1;
  localparam int LO_W = LANE_W + 1;

  rm_state_e                st;
  logic [SRC_AW-1:0]        src_q;
  logic [BUF_AW-1:0]        dword_q;
  logic [LEN_W-1:0]         len_q;
  logic [PW-1:0]            stride_q;
  logic                     pad_en_q;
  logic [PW-1:0]            pos_q;
  logic [WORD_BYTES*8-1:0]  acc_data;
  logic [WORD_BYTES-1:0]    acc_be;
  logic [7:0]               pad_val;

  logic unused_ignored;
  assign unused_ignored = ^{desc_sid, desc_hint, desc_dst[LANE_W-1:0]};

  rm_pad_reg #(.W(8)) u_pad (
    .clk(clk), .rst(rst), .we(pad_we), .wdata(pad_wdata), .value(pad_val)
  );

  logic [LANE_W-1:0] lane;
  logic [PW-1:0]     base, next_base;
  logic              last_beat;
  logic [LO_W-1:0]   mask_lo;
  logic [WORD_BYTES-1:0] pad_mask;
  logic [BUF_AW-1:0] word_idx;

  assign lane      = pos_q[LANE_W-1:0];
  assign base      = {pos_q[PW-1:LANE_W], {LANE_W{1'b0}}};
  assign next_base = base + PW'(WORD_BYTES);
  assign last_beat = (pos_q + PW'(1)) == {1'b0, len_q};
  assign mask_lo   = (st == ST_PAD) ? '0 : ({1'b0, lane} + LO_W'(1));
  assign word_idx  = dword_q + BUF_AW'(pos_q >> LANE_W);

  rm_lane_mask #(.LANES(WORD_BYTES), .PW(PW), .LO_W(LO_W)) u_mask (
    .base(base), .limit(stride_q), .lo(mask_lo), .mask(pad_mask)
  );

  // Merge the arriving byte (and trailing pad on the last beat) into the word.
  logic [WORD_BYTES*8-1:0] m_data;
  logic [WORD_BYTES-1:0]   m_be;
  always_comb begin
    m_data = acc_data;
    m_be   = acc_be;
    m_data[lane*8 +: 8] = rd_beat_data;
    m_be[lane] = 1'b1;
    if (last_beat && pad_en_q) begin
      for (int l = 0; l < WORD_BYTES; l++)
        if (pad_mask[l]) m_data[l*8 +: 8] = pad_val;
      m_be = m_be | pad_mask;
    end
  end

  assign desc_ready   = (st == ST_IDLE);
  assign rd_req_valid = (st == ST_REQ);
  assign rd_req_addr  = src_q;
  assign rd_req_len   = len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      wr_en    <= 1'b0;
      wr_be    <= '0;
      wr_addr  <= '0;
      acc_be   <= '0;
      pos_q    <= '0;
      src_q    <= '0;
      len_q    <= '0;
      stride_q <= '0;
      dword_q  <= '0;
      pad_en_q <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      case (st)
        ST_IDLE: if (desc_valid) begin
          src_q    <= desc_src;
          dword_q  <= desc_dst[BUF_AW+4:LANE_W];
          len_q    <= desc_len;
          stride_q <= {1'b0, desc_stride};
          pad_en_q <= desc_pad_en;
          pos_q    <= '0;
          acc_be   <= '0;
          if (desc_len != '0)                          st <= ST_REQ;
          else if (desc_pad_en && desc_stride != '0)   st <= ST_PAD;
        end
        ST_REQ: if (rd_req_ready) st <= ST_DATA;
        ST_DATA: if (rd_beat_valid) begin
          if (lane == LANE_W'(WORD_BYTES - 1) || last_beat) begin
            wr_en   <= 1'b1;
            wr_addr <= word_idx;
            wr_data <= m_data;
            wr_be   <= m_be;
            acc_be  <= '0;
          end else begin
            acc_data <= m_data;
            acc_be   <= m_be;
          end
          if (last_beat) begin
            if (pad_en_q && next_base < stride_q) begin
              pos_q <= next_base;
              st    <= ST_PAD;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            pos_q <= pos_q + PW'(1);
          end
        end
        ST_PAD: begin
          wr_en   <= 1'b1;
          wr_addr <= word_idx;
          wr_data <= {WORD_BYTES{pad_val}};
          wr_be   <= pad_mask;
          pos_q   <= next_base;
          if (next_base >= stride_q) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rm_checker.sv
module rm_checker #(
  parameter int SRC_AW = 40,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic [LEN_W-1:0]  desc_len,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [SRC_AW-1:0] rd_req_addr,
  input logic [LEN_W-1:0]  rd_req_len,
  input logic              wr_en,
  input logic [31:0]       wr_be
);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_len));

  assert_req_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> rd_req_len != '0);

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
    desc_valid && desc_ready && desc_len != '0 |=> !desc_ready);

  assert_no_req_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    desc_ready |-> !rd_req_valid);

  assert_write_has_bytes_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_be != '0);
endmodule

bind row_mover rm_checker #(.SRC_AW(SRC_AW), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
  .desc_len(desc_len), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len), .wr_en(wr_en), .wr_be(wr_be)
);

// File: tb/sim_row_mover.sv
module sim_row_mover;
  localparam int CLK_PERIOD = 10;
  localparam int SRC_AW = 40, BUF_AW = 10, LEN_W = 16;

  logic clk = 0, rst = 1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic pad_we = 0; logic [7:0] pad_wdata = 0;
  logic desc_valid = 0, desc_ready, desc_pad_en = 0;
  logic [SRC_AW-1:0] desc_src = 0; logic [BUF_AW+4:0] desc_dst = 0;
  logic [LEN_W-1:0] desc_len = 0, desc_stride = 0;
  logic [3:0] desc_sid = 0; logic [1:0] desc_hint = 0;
  logic rd_req_valid, rd_req_ready = 0;
  logic [SRC_AW-1:0] rd_req_addr; logic [LEN_W-1:0] rd_req_len;
  logic rd_beat_valid; logic [7:0] rd_beat_data;
  logic wr_en; logic [BUF_AW-1:0] wr_addr; logic [255:0] wr_data; logic [31:0] wr_be;

  row_mover u0 (.*);

  int tests = 0, fails = 0;
  int cyc = 0, nreq = 0, nwr = 0, asc_err = 0, row_id = 0, prev_row = -1;
  logic [SRC_AW-1:0] last_req_addr; logic [LEN_W-1:0] last_req_len;
  logic [BUF_AW-1:0] prev_addr;
  logic [255:0] buf_mem [0:(1<<BUF_AW)-1];
  logic [LEN_W-1:0] rem; logic [SRC_AW-1:0] ptr;

  function automatic logic [7:0] gm_byte(input logic [SRC_AW-1:0] a);
    logic [SRC_AW-1:0] t;
    t = a * 40'd13 + 40'd7;
    return t[7:0] ^ a[15:8];
  endfunction

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) rd_req_ready <= (cyc % 3 != 0);

  // global memory model: byte beats with gaps
  always @(posedge clk) begin
    if (rst) begin rd_beat_valid <= 0; rem <= 0; end
    else begin
      rd_beat_valid <= 0;
      if (rd_req_valid && rd_req_ready) begin
        rem <= rd_req_len; ptr <= rd_req_addr; nreq <= nreq + 1;
        last_req_addr <= rd_req_addr; last_req_len <= rd_req_len;
      end else if (rem != 0 && cyc % 4 != 3) begin
        rd_beat_valid <= 1; rd_beat_data <= gm_byte(ptr);
        ptr <= ptr + 1; rem <= rem - 1;
      end
    end
  end

  // buffer model
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < (1<<BUF_AW); i++) buf_mem[i] <= {32{8'hEE}};
    end else if (wr_en) begin
      for (int b = 0; b < 32; b++)
        if (wr_be[b]) buf_mem[wr_addr][b*8 +: 8] <= wr_data[b*8 +: 8];
      nwr <= nwr + 1;
      if (prev_row == row_id && wr_addr <= prev_addr) asc_err <= asc_err + 1;
      prev_row <= row_id; prev_addr <= wr_addr;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic set_pad(input logic [7:0] v);
    @(negedge clk); pad_we = 1; pad_wdata = v;
    @(negedge clk); pad_we = 0;
  endtask

  task automatic run_row(input string tag, input logic [SRC_AW-1:0] src, input int dst,
                         input int len, input int stride, input bit pad, input logic [7:0] padv,
                         input logic [3:0] sid, input logic [1:0] hint);
    int q0, w0, a0, words, span, bad, exp_w;
    logic [7:0] e, g;
    row_id++;
    @(negedge clk);
    while (!desc_ready) @(negedge clk);
    q0 = nreq; w0 = nwr; a0 = asc_err;
    desc_valid = 1; desc_src = src; desc_dst = (BUF_AW+5)'(dst);
    desc_len = LEN_W'(len); desc_stride = LEN_W'(stride); desc_pad_en = pad;
    desc_sid = sid; desc_hint = hint;
    @(negedge clk); desc_valid = 0;
    if (len != 0 || (pad && stride != 0))
      chk(desc_ready == 0, "R8", "busy after accept", int'(desc_ready), 0);
    while (!desc_ready) @(negedge clk);
    @(negedge clk);
    span  = (len > stride) ? len : stride;
    words = (span + 31) / 32 + 1;
    bad = 0;
    for (int o = 0; o < words * 32; o++) begin
      if (o < len) e = gm_byte(src + SRC_AW'(o));
      else if (pad && o < stride) e = padv;
      else e = 8'hEE;
      g = buf_mem[dst/32 + o/32][(o%32)*8 +: 8];
      if (g != e) begin
        if (bad == 0) $display("FAIL %s byte %0d: actual %0h expected %0h", tag, o, g, e);
        bad++;
      end
    end
    chk(bad == 0, tag, "row content mismatches", bad, 0);
    exp_w = pad ? (stride + 31) / 32 : (len + 31) / 32;
    chk(nwr - w0 == exp_w, "R10", "write count", nwr - w0, exp_w);
    chk(asc_err == a0, "R10", "ascending word addresses", asc_err - a0, 0);
    chk(nreq - q0 == (len != 0 ? 1 : 0), "R2", "request count", nreq - q0, (len != 0 ? 1 : 0));
    if (len != 0) begin
      chk(last_req_addr == src, "R2", "request address", int'(last_req_addr), int'(src));
      chk(int'(last_req_len) == len, "R2", "request length", int'(last_req_len), len);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        chk(desc_ready == 1, "R1", "desc_ready after reset", int'(desc_ready), 1);
        chk(rd_req_valid == 0, "R1", "rd_req_valid after reset", int'(rd_req_valid), 0);
        chk(wr_en == 0, "R1", "wr_en after reset", int'(wr_en), 0);
        // R3 aligned, whole words, no pad
        run_row("R3", 40'h100, 'h0000, 64, 64, 0, 8'h00, 0, 0);
        // R3 / R5 unaligned source, partial last word, no pad beyond length
        run_row("R5", 40'h1003, 'h0400, 45, 96, 0, 8'h00, 0, 0);
        // R4 200 bytes into 256 stride: 56 pad bytes
        set_pad(8'hA5);
        run_row("R4", 40'h2011, 'h0800, 200, 256, 1, 8'hA5, 0, 0);
        // R6 new pad value, merged word plus partial pad word
        set_pad(8'h3C);
        run_row("R6", 40'h3007, 'h1000, 7, 40, 1, 8'h3C, 0, 0);
        // R7 zero length with pad, then without
        run_row("R7", 40'h4000, 'h1400, 0, 64, 1, 8'h3C, 0, 0);
        run_row("R7", 40'h4000, 'h1800, 0, 64, 0, 8'h3C, 0, 0);
        // R9 same row with other stream id and hint
        run_row("R9", 40'h1003, 'h1C00, 45, 96, 1, 8'h3C, 4'hF, 2'h3);
        run_row("R9", 40'h1003, 'h2000, 45, 96, 1, 8'h3C, 4'h0, 2'h0);
        // R3 long unaligned row with word-ending length and pad
        run_row("R3", 40'hFF_0000_001F, 'h2400, 96, 160, 1, 8'h3C, 4'h2, 2'h1);
      end
      begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule